// File: doc/BRIEF.md
# Burst-of-two double-data-rate SRAM front end

The block models the synchronous control and data path of a double-data-rate SRAM whose every access carries two data words. One internal clock runs at twice the K rate. Each rising edge of it stands for either a rise of K or a rise of its complement K#. The block generates a phase flag that tells the two kinds of edge apart.

A command (load strobe, read/write select, address) is taken only on K edges, so a new burst can begin once per full K cycle. For a write, the two data beats follow on the next K edge and the K# edge after it. Each beat carries its own active-low byte write mask. For a read, two beats come back after one cycle or one and a half cycles, chosen by a latency-mode input.

A one-bit burst counter selects the word of the pair for each beat. A configuration parameter decides whether that counter starts at word 0 or takes the address LSB as its start value. A behavioural storage array holds the data.

Top module: `ddr_burst2_sram`

## Requirements
- R1: While rst is high (synchronous, active high) and on the first edge after it, rdOe is 0 and rdData is 0; kPhase is 1 during reset. Memory contents are not cleared.
- R2: kPhase toggles on every clk edge. A value of 1 means the coming edge is a K edge. ldStrobe is acted on only at edges where kPhase was 1; a strobe at a K# edge has no effect on memory or on the outputs.
- R3: For a write (rdWr = 0) loaded at K edge n, the first beat's wrData/byteWeN are captured at edge n+2 (the next K edge), and the second beat's at edge n+3 (K#).
- R4: With WIDE_CFG = 1, the row is addr[ADDR_W-1:1] and the first beat uses word addr[0]. With WIDE_CFG = 0, the row is the whole addr and the first beat always uses word 0.
- R5: The second beat of every burst, read or write, uses the other word of the same row than the first beat.
- R6: byteWeN bit b, when 0, writes wrData[8b+7:8b] of that beat into the stored word. When 1, it leaves that byte unchanged. Each beat uses the mask present at its own capture edge.
- R7: latMode is sampled with the read command. If latMode = 0, the first read beat is on rdData after edge n+2 and the second after edge n+3. If latMode = 1, the beats appear after edges n+3 and n+4.
- R8: rdOe is 1 exactly while a read beat is on rdData. Otherwise rdOe is 0 and rdData is 0.
- R9: Each read beat returns the memory contents just before the edge that drives it. A read loaded right after a write to the same row returns the newly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the K rate |
| rst | input | 1 | Synchronous active-high reset |
| ldStrobe | input | 1 | Command load strobe, active high |
| rdWr | input | 1 | 1 = read, 0 = write |
| latMode | input | 1 | 1 = 1.5-cycle read latency, 0 = 1-cycle |
| addr | input | ADDR_W | Command address |
| wrData | input | DATA_W | Write data beat |
| byteWeN | input | DATA_W/BYTE_W | Active-low byte write enables for the current beat |
| kPhase | output | 1 | 1 when the next clk edge is a K edge |
| rdData | output | DATA_W | Read data beat, 0 when idle |
| rdOe | output | 1 | Output enable: 1 while a read beat is driven |

## Verification
The embedded properties check on every cycle that commands never land on two adjacent edges. They also check that a write beat on a K edge is always followed by its partner on the K# edge, that this partner goes to the other word of the same row, and that rdOe never rises for a single beat alone. Some behaviours only the bench scenarios can show: stored values under random byte masks, the two latency settings, the burst start word in both configurations, and read-after-write and write-after-read ordering. The bench checks these by comparing both configurations against a behavioural memory model on every edge.

// File: rtl/ddr_burst2_pkg.sv
package ddr_burst2_pkg;
  // Strobes from control to datapath for one clk edge
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } strobe_t;
endpackage

// File: rtl/ddr_burst2_ctrl.sv
module ddr_burst2_ctrl
  import ddr_burst2_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int WIDE_CFG = 1,
  parameter int IDX_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ldStrobe,
  input  logic              rdWr,
  input  logic              latMode,
  input  logic [ADDR_W-1:0] addr,
  output logic              kPhase,
  output strobe_t           strb,
  output logic [IDX_W-1:0]  wrIdx,
  output logic [IDX_W-1:0]  rdIdx
);
  localparam int STAGES = 4;

  typedef struct packed {
    logic             valid;
    logic             isRd;
    logic             slow;
    logic [IDX_W-1:0] idx;
  } stage_t;

  stage_t pipe [STAGES];
  logic   kPhaseQ;
  logic [IDX_W-1:0] startIdx;

  // Burst counter seed: address LSB or forced word 0
  generate
    if (WIDE_CFG != 0) begin : g_wide
      assign startIdx = addr[IDX_W-1:0];
    end else begin : g_narrow
      assign startIdx = {addr, 1'b0};
    end
  endgenerate

  function automatic logic [IDX_W-1:0] otherWord(input logic [IDX_W-1:0] i);
    return {i[IDX_W-1:1], ~i[0]};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      kPhaseQ <= 1'b1;
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      kPhaseQ <= ~kPhaseQ;
      pipe[0] <= '{valid: kPhaseQ && ldStrobe, isRd: rdWr, slow: latMode, idx: startIdx};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign kPhase = kPhaseQ;

  always_comb begin
    strb  = '0;
    wrIdx = '0;
    rdIdx = '0;
    // write beats: first on the next K edge, second on the following K# edge
    if (pipe[1].valid && !pipe[1].isRd) begin
      strb.wrEn = 1'b1;
      wrIdx     = pipe[1].idx;
    end else if (pipe[2].valid && !pipe[2].isRd) begin
      strb.wrEn = 1'b1;
      wrIdx     = otherWord(pipe[2].idx);
    end
    // read beats, placed by the latency sampled with the command
    if (pipe[3].valid && pipe[3].isRd && pipe[3].slow) begin
      strb.rdEn = 1'b1;
      rdIdx     = otherWord(pipe[3].idx);
    end else if (pipe[2].valid && pipe[2].isRd && pipe[2].slow) begin
      strb.rdEn = 1'b1;
      rdIdx     = pipe[2].idx;
    end else if (pipe[2].valid && pipe[2].isRd && !pipe[2].slow) begin
      strb.rdEn = 1'b1;
      rdIdx     = otherWord(pipe[2].idx);
    end else if (pipe[1].valid && pipe[1].isRd && !pipe[1].slow) begin
      strb.rdEn = 1'b1;
      rdIdx     = pipe[1].idx;
    end
  end

  // R2: commands are accepted on alternate edges only
  a_r2_no_adjacent_loads: assert property (@(posedge clk) disable iff (rst)
    pipe[0].valid |=> !pipe[0].valid);

  // R3: a first write beat on a K edge is followed by its second beat
  a_r3_beat_pair: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && kPhaseQ) |=> strb.wrEn);

  // R5: the K# write beat targets the other word of the same row
  a_r5_other_word: assert property (@(posedge clk) disable iff (rst)
    (strb.wrEn && !kPhaseQ) |->
      ($past(strb.wrEn) && (wrIdx[0] != $past(wrIdx[0])) &&
       (wrIdx[IDX_W-1:1] == $past(wrIdx[IDX_W-1:1]))));
endmodule

// File: rtl/ddr_burst2_dpath.sv
module ddr_burst2_dpath
  import ddr_burst2_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  strobe_t                  strb,
  input  logic [IDX_W-1:0]         wrIdx,
  input  logic [IDX_W-1:0]         rdIdx,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W/BYTE_W-1:0] byteWeN,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdOe
);
  localparam int NBYTES = DATA_W / BYTE_W;
  localparam int DEPTH  = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // storage is not reset
  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int b = 0; b < NBYTES; b++) begin
        if (!byteWeN[b]) mem[wrIdx][b*BYTE_W +: BYTE_W] <= wrData[b*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdOe   <= 1'b0;
      rdData <= '0;
    end else begin
      rdOe   <= strb.rdEn;
      rdData <= strb.rdEn ? mem[rdIdx] : '0;
    end
  end

  // R8: read beats are never driven singly
  a_r8_beats_in_pairs: assert property (@(posedge clk) disable iff (rst)
    $rose(rdOe) |=> rdOe);
endmodule

// File: rtl/ddr_burst2_sram.sv
module ddr_burst2_sram
  import ddr_burst2_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 16,
  parameter int BYTE_W   = 8,
  parameter int WIDE_CFG = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ldStrobe,
  input  logic                     rdWr,
  input  logic                     latMode,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [DATA_W/BYTE_W-1:0] byteWeN,
  output logic                     kPhase,
  output logic [DATA_W-1:0]        rdData,
  output logic                     rdOe
);
  localparam int ROW_W = (WIDE_CFG != 0) ? ADDR_W - 1 : ADDR_W;
  localparam int IDX_W = ROW_W + 1;

  strobe_t          strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] rdIdx;

  ddr_burst2_ctrl #(.ADDR_W(ADDR_W), .WIDE_CFG(WIDE_CFG), .IDX_W(IDX_W)) i_ctrl (
    .clk(clk), .rst(rst), .ldStrobe(ldStrobe), .rdWr(rdWr), .latMode(latMode),
    .addr(addr), .kPhase(kPhase), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx)
  );

  ddr_burst2_dpath #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) i_dpath (
    .clk(clk), .rst(rst), .strb(strb), .wrIdx(wrIdx), .rdIdx(rdIdx),
    .wrData(wrData), .byteWeN(byteWeN), .rdData(rdData), .rdOe(rdOe)
  );
endmodule

// File: tb/test_ddr_burst2_sram.sv
module test_ddr_burst2_sram;
  logic clk = 1'b0;
  logic rst, ld, rdWr, latMode;
  logic [3:0]  addr;
  logic [15:0] wrData;
  logic [1:0]  beN;
  logic kphW, kphN, oeW, oeN;
  logic [15:0] datW, datN;

  always #10 clk = ~clk;

  ddr_burst2_sram #(.ADDR_W(4), .DATA_W(16), .BYTE_W(8), .WIDE_CFG(1)) i_ddr_burst2_sram (
    .clk(clk), .rst(rst), .ldStrobe(ld), .rdWr(rdWr), .latMode(latMode), .addr(addr),
    .wrData(wrData), .byteWeN(beN), .kPhase(kphW), .rdData(datW), .rdOe(oeW));

  ddr_burst2_sram #(.ADDR_W(4), .DATA_W(16), .BYTE_W(8), .WIDE_CFG(0)) i_ddr_burst2_sram_narrow (
    .clk(clk), .rst(rst), .ldStrobe(ld), .rdWr(rdWr), .latMode(latMode), .addr(addr),
    .wrData(wrData), .byteWeN(beN), .kPhase(kphN), .rdData(datN), .rdOe(oeN));

  // reference model: index 1 = wide config, index 0 = narrow config
  logic [15:0] mdl [2][32];
  bit rdP [2][8];
  bit wrP [2][8];
  int rdX [2][8];
  int wrX [2][8];
  logic expOe [2];
  logic [15:0] expD [2];
  bit kphM = 1'b1;
  int tick = 0;

  int total = 0, failed = 0;
  string cur = "R1";
  bit maskOn = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      kphM = 1'b1;
      for (int c = 0; c < 2; c++) begin
        expOe[c] = 1'b0; expD[c] = '0;
        for (int s = 0; s < 8; s++) begin rdP[c][s] = 0; wrP[c][s] = 0; end
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int s, idx;
        s = tick % 8;
        if (rdP[c][s]) begin expOe[c] = 1'b1; expD[c] = mdl[c][rdX[c][s]]; end
        else begin expOe[c] = 1'b0; expD[c] = '0; end
        if (wrP[c][s]) begin
          for (int b = 0; b < 2; b++)
            if (!beN[b]) mdl[c][wrX[c][s]][b*8 +: 8] = wrData[b*8 +: 8];
        end
        rdP[c][s] = 0; wrP[c][s] = 0;
        if (kphM && ld) begin
          idx = (c == 1) ? int'(addr) : int'(addr) * 2;
          if (rdWr) begin
            rdP[c][(tick + 2 + int'(latMode)) % 8] = 1; rdX[c][(tick + 2 + int'(latMode)) % 8] = idx;
            rdP[c][(tick + 3 + int'(latMode)) % 8] = 1; rdX[c][(tick + 3 + int'(latMode)) % 8] = idx ^ 1;
          end else begin
            wrP[c][(tick + 2) % 8] = 1; wrX[c][(tick + 2) % 8] = idx;
            wrP[c][(tick + 3) % 8] = 1; wrX[c][(tick + 3) % 8] = idx ^ 1;
          end
        end
      end
      kphM = ~kphM;
      tick++;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // compare every edge, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check(cur, "kPhase wide", {31'b0, kphW}, {31'b0, kphM});
      check(cur, "kPhase narrow", {31'b0, kphN}, {31'b0, kphM});
      check(cur, "rdOe wide", {31'b0, oeW}, {31'b0, expOe[1]});
      check(cur, "rdOe narrow", {31'b0, oeN}, {31'b0, expOe[0]});
      check(cur, "rdData wide", {16'b0, datW}, {16'b0, expD[1]});
      check(cur, "rdData narrow", {16'b0, datN}, {16'b0, expD[0]});
    end
  end

  always @(negedge clk) begin
    wrData <= 16'($urandom);
    beN    <= maskOn ? 2'($urandom) : 2'b00;
  end

  task automatic cmd(input bit l, input bit r, input logic [3:0] a);
    do @(negedge clk); while (!kphM);
    ld = l; rdWr = r; addr = a;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic strayLoad(input logic [3:0] a);
    do @(negedge clk); while (kphM);
    ld = 1'b1; rdWr = 1'b0; addr = a;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic idle(input int k);
    repeat (k) cmd(0, 0, 4'd0);
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rst = 1'b1; ld = 1'b0; rdWr = 1'b0; latMode = 1'b0; addr = '0;
    cur = "R1";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R3: fill every location with two-beat writes
    cur = "R3";
    for (int a = 0; a < 16; a++) cmd(1, 0, 4'(a));
    idle(2);
    // R7: back-to-back reads, one-cycle latency
    cur = "R7";
    latMode = 1'b0;
    for (int a = 0; a < 16; a++) cmd(1, 1, 4'(a));
    idle(2);
    latMode = 1'b1;
    idle(1);
    for (int a = 15; a >= 0; a--) cmd(1, 1, 4'(a));
    idle(2);
    latMode = 1'b0;
    // R6: random byte masks on each beat
    cur = "R6";
    maskOn = 1'b1;
    for (int k = 0; k < 12; k++) cmd(1, 0, 4'((k * 5) % 16));
    maskOn = 1'b0;
    for (int a = 0; a < 16; a++) cmd(1, 1, 4'(a));
    idle(2);
    // R9: read, write, read and write-then-read on the same row, both latencies
    cur = "R9";
    for (int m = 0; m < 2; m++) begin
      latMode = 1'(m);
      idle(2);
      cmd(1, 1, 4'd6); cmd(1, 0, 4'd6); cmd(1, 1, 4'd6);
      cmd(1, 0, 4'd9); cmd(1, 1, 4'd9); cmd(1, 1, 4'd8);
      cmd(1, 0, 4'd3); cmd(1, 0, 4'd2); cmd(1, 1, 4'd2); cmd(1, 1, 4'd3);
      idle(2);
    end
    latMode = 1'b0;
    idle(2);
    // R2: strobes on K# edges must not write
    cur = "R2";
    for (int a = 0; a < 4; a++) strayLoad(4'(a));
    for (int a = 0; a < 4; a++) cmd(1, 1, 4'(a));
    idle(2);
    // R4/R5: odd and even start addresses decide word order per config
    cur = "R4";
    cmd(1, 0, 4'd5); cmd(1, 0, 4'd10); cmd(1, 1, 4'd4); cmd(1, 1, 4'd5);
    cmd(1, 1, 4'd10); cmd(1, 1, 4'd11);
    idle(2);
    cur = "R5";
    cmd(1, 0, 4'd13); idle(1); cmd(1, 1, 4'd12); idle(1); cmd(1, 1, 4'd13);
    idle(2);
    // R8: isolated reads separated by idle cycles
    cur = "R8";
    cmd(1, 1, 4'd7); idle(2); cmd(1, 1, 4'd1); idle(3);
    finishRun();
  end
endmodule